// File: doc/BRIEF.md
# Low-Power Lane Entry Sequence Detector

This block sits on the receive side of one bidirectional serial data lane. It watches the two single-ended low-power line bits in the low-power sample clock domain. It debounces each line state against a programmable minimum run length. It then follows the order in which the accepted states arrive, starting from the Stop state (both lines high).

The detector tells three requests apart by the order of their states:

- Escape entry: 11, 10, 00, 01, 00.
- High-speed entry: 11, 01, 00.
- Bus turnaround: 11, 10, 00, 10, 00.

For each request it gives a single-cycle pulse, and it reports the lane's current mode. It also flags the return from escape mode to Stop. Any step that breaks a sequence raises an error pulse. The machine then waits for Stop again.

Escape payload, high-speed data and contention handling belong to neighbouring blocks. They use the mode output to know when to act.

Top module: `lp_entry_detect`

## Requirements
- R1: After reset the mode output is 0 (control) with no pulse. The machine takes no request until it has accepted line state 11 (Stop). The line state is `line_i[1]` = positive line and `line_i[0]` = negative line.
- R2: A line state is accepted only after `cfg_min_stable` consecutive identical samples; a value of 0 acts as 1. A shorter excursion that returns to the accepted state has no effect.
- R3: From Stop, accepted states 10, 00, 01, 00 produce one `esc_req_o` pulse. The mode then becomes 2 (escape).
- R4: From Stop, accepted states 01, 00 produce one `hs_req_o` pulse. The mode becomes 1 (high-speed) and stays 1 until state 11 is accepted, which returns it to 0 with no pulse.
- R5: From Stop, accepted states 10, 00, 10, 00 produce one `turn_req_o` pulse. The mode becomes 3 (turnaround) and stays 3 until state 11 is accepted, which returns it to 0 with no pulse.
- R6: In escape mode, accepting 10 followed by 11 produces one `esc_exit_o` pulse and mode 0. Payload states (01, 00, and 10 followed by 00) produce no pulse.
- R7: An accepted state that does not continue a partly seen request sequence produces one `seq_err_o` pulse. The same applies to 00 accepted in Stop. The machine then waits for Stop; if the offending state is 11 itself, the machine is already in Stop.
- R8: Each of the five pulse outputs is high for at most one cycle per event, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-power sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 2 | Sampled line state, bit 1 positive line, bit 0 negative line |
| cfg_min_stable | input | CNT_W | Minimum consecutive samples for a state to be accepted (0 acts as 1) |
| esc_req_o | output | 1 | Escape entry detected (one-cycle pulse) |
| hs_req_o | output | 1 | High-speed entry detected (one-cycle pulse) |
| turn_req_o | output | 1 | Turnaround request detected (one-cycle pulse) |
| esc_exit_o | output | 1 | Escape exit to Stop detected (one-cycle pulse) |
| seq_err_o | output | 1 | Out-of-order line state (one-cycle pulse) |
| mode_o | output | 2 | 0 control, 1 high-speed, 2 escape, 3 turnaround |

## Verification
The assertions assume that `line_i` is already synchronised to `clk`. They also assume that `cfg_min_stable` changes only while the line rests in one state, so that a run length is never judged against two thresholds.

The stimulus follows these assumptions. It changes the line only at the falling clock edge and holds each state for a whole number of samples. It reprograms the threshold only while the lane sits in Stop. Glitches are injected as short runs, shorter than the threshold, inside otherwise legal sequences.

// File: rtl/lp_entry_pkg.sv
// Package: shared encodings for the low-power entry sequence detector.
// Assumes line state bit 1 is the positive line, bit 0 the negative line.
package lp_entry_pkg;

    typedef enum logic [1:0] {
        LN_00 = 2'b00,
        LN_01 = 2'b01,
        LN_10 = 2'b10,
        LN_11 = 2'b11
    } line_t;

    typedef enum logic [1:0] {
        MODE_CTRL = 2'd0,
        MODE_HS   = 2'd1,
        MODE_ESC  = 2'd2,
        MODE_TA   = 2'd3
    } lane_mode_t;

    typedef enum logic [3:0] {
        SQ_WAIT_STOP,
        SQ_STOP,
        SQ_A10,
        SQ_A10_00,
        SQ_ESC_01,
        SQ_TA_10,
        SQ_HS_01,
        SQ_HS_ACT,
        SQ_ESC_ACT,
        SQ_ESC_X10,
        SQ_TA_ACT
    } seq_state_t;

endpackage

// File: rtl/lp_state_filter.sv
// Module: lp_state_filter
// Debounces the 2-bit line state. A sample value is accepted once it has
// been seen on cfg_min consecutive samples (0 treated as 1) and it differs
// from the state accepted last; acceptance raises acc_stb for one cycle.
// Assumes line_i is synchronous to clk.
module lp_state_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       line_i,
    input  logic [CNT_W-1:0] cfg_min,
    output logic [1:0]       acc_state,
    output logic             acc_stb
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [1:0]       cand_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_nx;
    logic [CNT_W-1:0] min_eff;
    logic             take;

    // Length of the current run including this sample, and the accept decision.
    always_comb begin
        min_eff = (cfg_min == '0) ? ONE : cfg_min;
        if (line_i != cand_q)    run_nx = ONE;
        else if (run_q == RUN_MAX) run_nx = RUN_MAX;
        else                       run_nx = run_q + ONE;
        take = (run_nx >= min_eff) && (line_i != acc_state);
    end

    // Track the running candidate and publish accepted states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q    <= 2'b00;
            run_q     <= '0;
            acc_state <= 2'b00;
            acc_stb   <= 1'b0;
        end else begin
            cand_q  <= line_i;
            run_q   <= run_nx;
            acc_stb <= take;
            if (take) acc_state <= line_i;
        end
    end
endmodule

// File: rtl/lp_seq_fsm.sv
// Module: lp_seq_fsm
// Walks accepted line states through the Stop-based request sequences and
// issues registered one-cycle pulses plus the lane mode. Assumes each strobe
// carries a state different from the one before it.
module lp_seq_fsm
    import lp_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] st_i,
    input  logic       stb_i,
    output logic       esc_req,
    output logic       hs_req,
    output logic       turn_req,
    output logic       esc_exit,
    output logic       seq_err,
    output logic [1:0] mode
);
    seq_state_t cur_q, nxt;
    logic p_esc, p_hs, p_ta, p_exit, p_err;

    // Next-state and pulse decode for one accepted line state.
    always_comb begin
        nxt = cur_q;
        {p_esc, p_hs, p_ta, p_exit, p_err} = '0;
        if (stb_i) begin
            unique case (cur_q)
                SQ_WAIT_STOP: if (st_i == LN_11) nxt = SQ_STOP;
                SQ_STOP: begin
                    if (st_i == LN_10)      nxt = SQ_A10;
                    else if (st_i == LN_01) nxt = SQ_HS_01;
                    else begin p_err = 1'b1; nxt = SQ_WAIT_STOP; end
                end
                SQ_A10: begin
                    if (st_i == LN_00) nxt = SQ_A10_00;
                    else p_err = 1'b1;
                end
                SQ_A10_00: begin
                    if (st_i == LN_01)      nxt = SQ_ESC_01;
                    else if (st_i == LN_10) nxt = SQ_TA_10;
                    else p_err = 1'b1;
                end
                SQ_ESC_01: begin
                    if (st_i == LN_00) begin p_esc = 1'b1; nxt = SQ_ESC_ACT; end
                    else p_err = 1'b1;
                end
                SQ_TA_10: begin
                    if (st_i == LN_00) begin p_ta = 1'b1; nxt = SQ_TA_ACT; end
                    else p_err = 1'b1;
                end
                SQ_HS_01: begin
                    if (st_i == LN_00) begin p_hs = 1'b1; nxt = SQ_HS_ACT; end
                    else p_err = 1'b1;
                end
                SQ_HS_ACT, SQ_TA_ACT: if (st_i == LN_11) nxt = SQ_STOP;
                SQ_ESC_ACT: if (st_i == LN_10) nxt = SQ_ESC_X10;
                SQ_ESC_X10: begin
                    if (st_i == LN_11) begin p_exit = 1'b1; nxt = SQ_STOP; end
                    else nxt = SQ_ESC_ACT;
                end
                default: nxt = SQ_WAIT_STOP;
            endcase
            // A broken sequence waits for Stop, unless the culprit is Stop itself.
            if (p_err) nxt = (st_i == LN_11) ? SQ_STOP : SQ_WAIT_STOP;
        end
    end

    // State and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= SQ_WAIT_STOP;
            {esc_req, hs_req, turn_req, esc_exit, seq_err} <= '0;
        end else begin
            cur_q <= nxt;
            {esc_req, hs_req, turn_req, esc_exit, seq_err} <= {p_esc, p_hs, p_ta, p_exit, p_err};
        end
    end

    // Mode derived from the registered state.
    always_comb begin
        unique case (cur_q)
            SQ_HS_ACT:              mode = MODE_HS;
            SQ_ESC_ACT, SQ_ESC_X10: mode = MODE_ESC;
            SQ_TA_ACT:              mode = MODE_TA;
            default:                mode = MODE_CTRL;
        endcase
    end
endmodule

// File: rtl/lp_entry_detect.sv
// Module: lp_entry_detect (top)
// Low-power entry sequence detector for one data lane: a debounce filter
// followed by the request sequencer. Assumes line_i already synchronised.
module lp_entry_detect #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       line_i,
    input  logic [CNT_W-1:0] cfg_min_stable,
    output logic             esc_req_o,
    output logic             hs_req_o,
    output logic             turn_req_o,
    output logic             esc_exit_o,
    output logic             seq_err_o,
    output logic [1:0]       mode_o
);
    logic [1:0] acc_st;
    logic       acc_stb;

    lp_state_filter #(.CNT_W(CNT_W)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (line_i),
        .cfg_min   (cfg_min_stable),
        .acc_state (acc_st),
        .acc_stb   (acc_stb)
    );

    lp_seq_fsm u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_i     (acc_st),
        .stb_i    (acc_stb),
        .esc_req  (esc_req_o),
        .hs_req   (hs_req_o),
        .turn_req (turn_req_o),
        .esc_exit (esc_exit_o),
        .seq_err  (seq_err_o),
        .mode     (mode_o)
    );
endmodule

// File: rtl/lp_entry_detect_chk.sv
// Module: lp_entry_detect_chk
// Property checker for lp_entry_detect, attached through bind.
module lp_entry_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       esc_req_o,
    input logic       hs_req_o,
    input logic       turn_req_o,
    input logic       esc_exit_o,
    input logic       seq_err_o,
    input logic [1:0] mode_o
);
    // R8
    pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({esc_req_o, hs_req_o, turn_req_o, esc_exit_o, seq_err_o}));
    // R8
    hs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req_o |=> !hs_req_o);
    // R3
    esc_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        esc_req_o |-> mode_o == 2'd2);
    // R4
    hs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req_o |-> mode_o == 2'd1);
    // R5
    ta_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_req_o |-> mode_o == 2'd3);
    // R6
    exit_from_esc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        esc_exit_o |-> (mode_o == 2'd0) && ($past(mode_o) == 2'd2));
    // R4
    hs_leave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == 2'd1 && mode_o != 2'd1) |-> mode_o == 2'd0 && !seq_err_o);
endmodule

bind lp_entry_detect lp_entry_detect_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .esc_req_o  (esc_req_o),
    .hs_req_o   (hs_req_o),
    .turn_req_o (turn_req_o),
    .esc_exit_o (esc_exit_o),
    .seq_err_o  (seq_err_o),
    .mode_o     (mode_o)
);

// File: tb/lp_entry_detect_tb.sv
// Scoreboard bench: driver tasks queue expected pulse events, a monitor
// pops and compares them as the design reports events.
module lp_entry_detect_tb;
    localparam int CNT_W = 8;
    // event codes: 1 esc, 2 hs, 3 turnaround, 4 esc exit, 5 error

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       line_i = 2'b00;
    logic [CNT_W-1:0] cfg = 8'd3;
    logic esc_req_o, hs_req_o, turn_req_o, esc_exit_o, seq_err_o;
    logic [1:0] mode_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    lp_entry_detect #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .cfg_min_stable(cfg),
        .esc_req_o(esc_req_o), .hs_req_o(hs_req_o), .turn_req_o(turn_req_o),
        .esc_exit_o(esc_exit_o), .seq_err_o(seq_err_o), .mode_o(mode_o)
    );

    task automatic expect_ev(input int code, input string tag);
        exp_q.push_back(code);
        tag_q.push_back(tag);
    endtask

    task automatic hold(input logic [1:0] v, input int n);
        @(negedge clk);
        line_i = v;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic chk_mode(input logic [1:0] e, input string tag);
        n_cmp++;
        if (mode_o !== e) begin
            n_bad++;
            $display("FAIL %s mode actual=%0d expected=%0d", tag, mode_o, e);
        end
    endtask

    // Monitor: every reported event is popped against the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            automatic int code = 0;
            automatic int hits = esc_req_o + hs_req_o + turn_req_o + esc_exit_o + seq_err_o;
            if (esc_req_o) code = 1;
            if (hs_req_o) code = 2;
            if (turn_req_o) code = 3;
            if (esc_exit_o) code = 4;
            if (seq_err_o) code = 5;
            if (hits > 1) begin
                n_cmp++; n_bad++;
                $display("FAIL R8 simultaneous pulses actual=%0d expected=1", hits);
            end else if (code != 0) begin
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R2/R6 unexpected event actual=%0d expected=none", code);
                end else begin
                    automatic int e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    if (e != code) begin
                        n_bad++;
                        $display("FAIL %s event actual=%0d expected=%0d", t, code, e);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            while (exp_q.size() > 0) begin
                automatic int e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                n_cmp++; n_bad++;
                $display("FAIL %s missing event actual=none expected=%0d", t, e);
            end
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_mode(2'd0, "R1 reset");
        // R1: no request before Stop is seen
        hold(2'b01, 6); hold(2'b00, 6);
        chk_mode(2'd0, "R1 no stop yet");
        hold(2'b11, 6);
        // R3: escape entry
        hold(2'b10, 6); hold(2'b00, 6); hold(2'b01, 6);
        expect_ev(1, "R3");
        hold(2'b00, 6);
        chk_mode(2'd2, "R3 escape mode");
        // R6: payload states, then exit
        hold(2'b01, 6); hold(2'b00, 6); hold(2'b10, 6); hold(2'b00, 6);
        chk_mode(2'd2, "R6 payload");
        hold(2'b10, 6);
        expect_ev(4, "R6");
        hold(2'b11, 6);
        chk_mode(2'd0, "R6 exit mode");
        // R4: high-speed entry, held until Stop
        hold(2'b01, 6);
        expect_ev(2, "R4");
        hold(2'b00, 40);
        chk_mode(2'd1, "R4 hs mode");
        hold(2'b11, 6);
        chk_mode(2'd0, "R4 back to stop");
        // R5: turnaround
        hold(2'b10, 6); hold(2'b00, 6); hold(2'b10, 6);
        expect_ev(3, "R5");
        hold(2'b00, 6);
        chk_mode(2'd3, "R5 ta mode");
        hold(2'b11, 6);
        chk_mode(2'd0, "R5 back to stop");
        // R7: broken sequence ending in Stop
        hold(2'b10, 6);
        expect_ev(5, "R7 10-11");
        hold(2'b11, 6);
        // R7: 00 directly from Stop, then wait for Stop
        expect_ev(5, "R7 stop-00");
        hold(2'b00, 6);
        hold(2'b01, 6);
        hold(2'b11, 6);
        hold(2'b01, 6);
        expect_ev(2, "R7 recovery");
        hold(2'b00, 6);
        hold(2'b11, 6);
        // R2: short excursions below threshold are ignored
        hold(2'b10, 2); hold(2'b11, 6);
        hold(2'b01, 2); hold(2'b11, 6);
        chk_mode(2'd0, "R2 glitch");
        hold(2'b01, 3);
        hold(2'b10, 1);
        expect_ev(2, "R2 exact threshold");
        hold(2'b00, 3);
        hold(2'b00, 3);
        chk_mode(2'd1, "R2 exact threshold mode");
        hold(2'b11, 6);
        // R2: zero threshold acts as one
        cfg = 8'd0;
        hold(2'b10, 1); hold(2'b00, 1); hold(2'b01, 1);
        expect_ev(1, "R2 zero threshold");
        hold(2'b00, 1);
        hold(2'b00, 4);
        chk_mode(2'd2, "R2 zero threshold mode");
        hold(2'b10, 1);
        expect_ev(4, "R6 fast exit");
        hold(2'b11, 6);
        chk_mode(2'd0, "R6 fast exit mode");
        hold(2'b11, 10);
        finish_run();
    end
endmodule